// File: doc/BRIEF.md
# Instruction Prefix and Operand Selector

This block is the decode front of a 16-bit register machine. It holds a one-byte fetch pipe. The byte in the pipe is the opcode that runs on the next step. While that opcode runs, the byte at the program counter is loaded into the pipe, and the block asks for the program counter to advance. For each executed opcode the block produces a dispatch index. The two alternate-mode status bits sit above the 8-bit opcode in that index, so one opcode byte can select among four opcode maps.

A small external decoder classifies the opcode in the pipe and passes that class to the block as a hint. Prefix opcodes change only the block's own state:
- the two alternate-mode bits;
- the selected source register;
- the selected destination register;
- a flag that ties source and destination together.

A normal opcode is reported as fired, together with the effective source and destination. It then returns the state to its defaults: mode 0, flag clear, and register 0 as both source and destination. When the tie flag is set, the source-select and destination-select classes turn into register moves.

Top module: `opsel_front`

## Requirements
- R1: After reset the pipe holds RESET_OPC (default 0x01), the mode is 0, the tie flag is clear, and `src_sel` and `dst_sel` are 0. Therefore `disp_idx` reads 0x001 and `op_fire` is low.
- R2: `disp_idx` equals {mode, pipe byte}. `pc_inc` is high exactly in cycles where `step` is high. At the clock edge of such a cycle, the pipe loads `fetch_byte`.
- R3: Bit 9 of `disp_idx` is the ALT2 bit and bit 8 is the ALT1 bit. Class 1 sets ALT1, class 2 sets ALT2 and class 3 sets both. With the default ALT_MERGE=1, the new bits are ORed with the bits already set.
- R4: With the tie flag clear, class 4 (source select) makes the opcode's low nibble the source. Class 5 (destination select) makes it the destination.
- R5: Class 6 (tie) sets the tie flag and makes the low nibble both source and destination. While the flag is set, source and destination stay equal.
- R6: Prefix classes (1, 2, 3, 6, and 4 or 5 with the tie flag clear) keep `op_fire` low and leave all other prefix state unchanged.
- R7: Class 0, and the unused class 7, fire `op_fire` with the current source and destination. After the edge, the mode, tie flag, source and destination are all cleared.
- R8: With the tie flag set, class 4 fires as a move whose source is the low nibble and whose destination is the tied register, and then clears the state.
- R9: With the tie flag set, class 5 fires as a move whose destination is the low nibble and whose source is the tied register, and then clears the state.
- R10: In a cycle with `step` low, the pipe and all prefix state hold their values, and `op_fire` and `pc_inc` are low.
- R11: When no select prefix is active, a fired opcode uses register 0 as source and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Execute the piped opcode and fetch the next byte |
| fetch_byte | input | 8 | Byte at the current program counter |
| op_class | input | 3 | Class hint for the piped opcode (0 plain, 1 ALT1, 2 ALT2, 3 ALT3, 4 source select, 5 destination select, 6 tie, 7 treated as plain) |
| disp_idx | output | 10 | Dispatch index {ALT2, ALT1, opcode} |
| src_sel | output | 4 | Effective source register number |
| dst_sel | output | 4 | Effective destination register number |
| op_fire | output | 1 | A non-prefix opcode executes this cycle |
| pc_inc | output | 1 | Request to advance the program counter |

## Verification
The assertions check four things on every cycle:
- the pipe captures the fetched byte on each step;
- the pipe and the prefix state are frozen while no step is given;
- a plain opcode leaves the state at its defaults;
- the tie flag always implies equal source and destination.

Some behaviour only the bench's scenarios can show. This covers the exact dispatch index across mode combinations, including the merging of ALT prefixes. It also covers which register each move form reports, and the defaults seen by opcodes that follow a clear. The bench compares all of these against its reference model on every cycle.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [2:0] {
      CLS_PLAIN = 3'd0,
      CLS_ALT1  = 3'd1,
      CLS_ALT2  = 3'd2,
      CLS_ALT3  = 3'd3,
      CLS_SRC   = 3'd4,
      CLS_DST   = 3'd5,
      CLS_TIE   = 3'd6,
      CLS_RSVD  = 3'd7
   } op_class_e;

   function automatic logic [MODE_W-1:0] alt_bits(input op_class_e c);
      case (c)
         CLS_ALT1: alt_bits = 2'b01;
         CLS_ALT2: alt_bits = 2'b10;
         CLS_ALT3: alt_bits = 2'b11;
         default:  alt_bits = 2'b00;
      endcase
   endfunction
endpackage

// File: rtl/opsel_pipe.sv
module opsel_pipe #(
   parameter int OPC_W = 8,
   parameter logic [OPC_W-1:0] RESET_OPC = 'h01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OPC_W-1:0] fetch_byte,
   output logic [OPC_W-1:0] pipe_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    pipe_q <= RESET_OPC;
      else if (load) pipe_q <= fetch_byte;
   end

   assert_pipe_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> pipe_q == $past(fetch_byte));
   assert_pipe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(pipe_q));
endmodule

// File: rtl/opsel_prefix.sv
module opsel_prefix
   import opsel_pkg::*;
#(
   parameter int OPC_W     = 8,
   parameter int SEL_W     = 4,
   parameter bit ALT_MERGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [2:0]        op_class,
   input  logic [OPC_W-1:0]  opcode,
   output logic [MODE_W-1:0] mode_o,
   output logic [SEL_W-1:0]  src_o,
   output logic [SEL_W-1:0]  dst_o,
   output logic              fire_o
);
   if (SEL_W > OPC_W) begin : g_bad_width
      $error("opsel_prefix: SEL_W must not exceed OPC_W");
   end

   op_class_e          cls;
   logic [SEL_W-1:0]   arg;
   logic [MODE_W-1:0]  mode_q, mode_n, alt_apply;
   logic               tie_q, tie_n, fire_c;
   logic [SEL_W-1:0]   src_q, src_n, dst_q, dst_n;

   assign cls = op_class_e'(op_class);
   assign arg = opcode[SEL_W-1:0];

   if (ALT_MERGE) begin : g_alt_merge
      assign alt_apply = mode_q | alt_bits(cls);
   end else begin : g_alt_replace
      assign alt_apply = alt_bits(cls);
   end

   always_comb begin
      mode_n = mode_q;
      tie_n  = tie_q;
      src_n  = src_q;
      dst_n  = dst_q;
      src_o  = src_q;
      dst_o  = dst_q;
      fire_c = 1'b0;
      case (cls)
         CLS_ALT1, CLS_ALT2, CLS_ALT3: mode_n = alt_apply;
         CLS_SRC: begin
            if (tie_q) begin
               fire_c = 1'b1;
               src_o  = arg;
            end else begin
               src_n = arg;
            end
         end
         CLS_DST: begin
            if (tie_q) begin
               fire_c = 1'b1;
               dst_o  = arg;
            end else begin
               dst_n = arg;
            end
         end
         CLS_TIE: begin
            tie_n = 1'b1;
            src_n = arg;
            dst_n = arg;
         end
         default: fire_c = 1'b1;
      endcase
      if (fire_c) begin
         mode_n = '0;
         tie_n  = 1'b0;
         src_n  = '0;
         dst_n  = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         tie_q  <= 1'b0;
         src_q  <= '0;
         dst_q  <= '0;
      end else if (step) begin
         mode_q <= mode_n;
         tie_q  <= tie_n;
         src_q  <= src_n;
         dst_q  <= dst_n;
      end
   end

   assign mode_o = mode_q;
   assign fire_o = step & fire_c;

   assert_plain_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (op_class == 3'd0)) |=> (mode_q == '0 && !tie_q && src_q == '0 && dst_q == '0));
   assert_tie_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tie_q |-> (src_q == dst_q));
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(mode_q) && $stable(tie_q) && $stable(src_q) && $stable(dst_q)));
endmodule

// File: rtl/opsel_front.sv
module opsel_front
   import opsel_pkg::*;
#(
   parameter int OPC_W     = 8,
   parameter int SEL_W     = 4,
   parameter logic [OPC_W-1:0] RESET_OPC = 'h01,
   parameter bit ALT_MERGE = 1'b1,
   localparam int DISP_W   = MODE_W + OPC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [OPC_W-1:0]  fetch_byte,
   input  logic [2:0]        op_class,
   output logic [DISP_W-1:0] disp_idx,
   output logic [SEL_W-1:0]  src_sel,
   output logic [SEL_W-1:0]  dst_sel,
   output logic              op_fire,
   output logic              pc_inc
);
   logic [OPC_W-1:0]  pipe_q;
   logic [MODE_W-1:0] mode_q;

   opsel_pipe #(.OPC_W(OPC_W), .RESET_OPC(RESET_OPC)) u_pipe (
      .clk(clk), .rst_n(rst_n), .load(step),
      .fetch_byte(fetch_byte), .pipe_q(pipe_q));

   opsel_prefix #(.OPC_W(OPC_W), .SEL_W(SEL_W), .ALT_MERGE(ALT_MERGE)) u_prefix (
      .clk(clk), .rst_n(rst_n), .step(step), .op_class(op_class),
      .opcode(pipe_q), .mode_o(mode_q), .src_o(src_sel), .dst_o(dst_sel),
      .fire_o(op_fire));

   assign disp_idx = {mode_q, pipe_q};
   assign pc_inc   = step;

   assert_fire_needs_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_fire |-> pc_inc);
endmodule

// File: tb/opsel_front_test.sv
module opsel_front_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step = 1'b0;
   logic [7:0] fetch_byte = 8'h00;
   logic [2:0] op_class = 3'd0;
   logic [9:0] disp_idx;
   logic [3:0] src_sel, dst_sel;
   logic       op_fire, pc_inc;

   int checks = 0, failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   opsel_front uut (
      .clk(clk), .rst_n(rst_n), .step(step), .fetch_byte(fetch_byte),
      .op_class(op_class), .disp_idx(disp_idx), .src_sel(src_sel),
      .dst_sel(dst_sel), .op_fire(op_fire), .pc_inc(pc_inc));

   byte unsigned prog[64];
   int pc = 0;
   int m_pipe = 1, m_mode = 0, m_tie = 0, m_src = 0, m_dst = 0;

   function automatic int cls_of(int b);
      if (b == 8'h3D) return 1;
      if (b == 8'h3E) return 2;
      if (b == 8'h3F) return 3;
      if (b == 8'h4F) return 7;
      if ((b >> 4) == 4'hB) return 4;
      if ((b >> 4) == 4'h1) return 5;
      if ((b >> 4) == 4'h2) return 6;
      return 0;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic tick(bit st);
      int c, nib, e_src, e_dst, e_fire;
      int n_mode, n_tie, n_src, n_dst;
      string tag;
      c = cls_of(m_pipe);
      nib = m_pipe & 15;
      step = st; fetch_byte = prog[pc]; op_class = 3'(c);
      #2;
      e_src = m_src; e_dst = m_dst; e_fire = 0;
      n_mode = m_mode; n_tie = m_tie; n_src = m_src; n_dst = m_dst;
      tag = "R10";
      case (c)
         1, 2, 3: begin n_mode = m_mode | c; tag = "R3"; end
         4: if (m_tie != 0) begin e_fire = 1; e_src = nib; tag = "R8"; end
            else begin n_src = nib; tag = "R4"; end
         5: if (m_tie != 0) begin e_fire = 1; e_dst = nib; tag = "R9"; end
            else begin n_dst = nib; tag = "R4"; end
         6: begin n_tie = 1; n_src = nib; n_dst = nib; tag = "R5"; end
         default: begin e_fire = 1; tag = (m_src == 0 && m_dst == 0) ? "R11" : "R7"; end
      endcase
      if (e_fire != 0) begin n_mode = 0; n_tie = 0; n_src = 0; n_dst = 0; end
      if (!st) begin e_fire = 0; tag = "R10"; end
      chk("R2", "disp_idx", disp_idx, m_mode * 256 + m_pipe);
      chk("R2", "pc_inc", pc_inc, st);
      chk(tag, "src_sel", src_sel, e_src);
      chk(tag, "dst_sel", dst_sel, e_dst);
      chk(e_fire != 0 ? tag : "R6", "op_fire", op_fire, e_fire);
      @(posedge clk);
      if (st) begin
         m_pipe = prog[pc];
         pc = (pc + 1) % 64;
         m_mode = n_mode; m_tie = n_tie; m_src = n_src; m_dst = n_dst;
      end
      @(negedge clk);
   endtask

   initial begin
      byte unsigned seq[$] = '{8'h05, 8'h3D, 8'h06, 8'h3E, 8'h07, 8'h3F, 8'h08,
         8'h3D, 8'h3E, 8'h09, 8'hB3, 8'h14, 8'h0A, 8'h25, 8'hB7, 8'h26, 8'h19,
         8'h2A, 8'h3D, 8'h0B, 8'hB2, 8'hB3, 8'h0C, 8'h1F, 8'h3F, 8'hB1, 8'h0D,
         8'h27, 8'h3E, 8'hBC, 8'h28, 8'h1E, 8'h4F, 8'h3E, 8'h2C, 8'h4F, 8'h00};
      for (int i = 0; i < 64; i++)
         prog[i] = (i < seq.size()) ? seq[i] : 8'((i * 13 + 1) & 255);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R1", "disp_idx", disp_idx, 10'h001);
      chk("R1", "src_sel", src_sel, 0);
      chk("R1", "dst_sel", dst_sel, 0);
      chk("R1", "op_fire", op_fire, 0);
      @(negedge clk);
      for (int k = 0; k < 200; k++) tick((k % 5) != 4);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule